// File: doc/BRIEF.md
# Nine-bit three-wire serial LCD writer

This block turns one LCD controller command, plus up to two optional parameter bytes, into words on a three-wire serial link: an active-low select, a serial clock and a data-out line. Each word is nine bits wide. The extra bit is sent first and marks the word as a command or a parameter. The block can also read a register. For a read it sends the command word, then opens a second select window and clocks nine bits in from a separate data-in line.

The host sets the command byte, the two parameter bytes and their present flags, and the read/write choice. It then pulses `start` while the block is idle. `busy` stays high for the whole transaction, including the setup gap at the start and the closing gap at the end. `done` marks the end with a single-cycle pulse. All serial timing is counted in half-bit ticks from a clock-enable divider. The divider ratio and both gap lengths are parameters.

Top module: `lcd3w_writer`

## Requirements
- R1: A word is nine bits, sent most significant bit first. Bit 8 is 0 for a command word and 1 for a parameter word. Bits 7..0 carry the byte.
- R2: Each word has its own select-low window of exactly 18×HALF_DIV clock cycles. The window holds nine clock pulses. Each high phase and each low phase lasts HALF_DIV cycles, and the first rising edge comes HALF_DIV cycles after select falls. The clock is never high while select is high.
- R3: Data-out changes only while the serial clock is low. It holds steady for the whole of every high phase.
- R4: Select falls for the first word exactly SETUP_HALVES×HALF_DIV cycles after `busy` rises. Between words, select stays high for exactly GAP_HALVES×HALF_DIV cycles. Data-out is high during both kinds of gap.
- R5: If the first parameter is flagged present, a parameter word follows the command word. The second parameter word is sent only when both flags are present. If the first flag is absent, the second parameter is ignored whatever its flag.
- R6: A read sends the command word. Its second window carries nine clock pulses with data-out held high. Data-in is sampled one cycle after each falling clock edge and assembled MSB first into `rdata`, which is valid when `done` pulses.
- R7: When the last word ends, select goes high and the clock and data-out go low. `busy` falls exactly GAP_HALVES×HALF_DIV cycles after the last select rise. `done` is high for exactly that one cycle and never while `busy` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The transaction in progress and its words are left unchanged, and no second transaction follows.
- R9: After reset, select is high, the clock and data-out are low, `busy` and `done` are low, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| rd_en | input | 1 | 1 = register read, 0 = write |
| cmd | input | 8 | Command byte |
| prm0 | input | 8 | First parameter byte |
| prm0_vld | input | 1 | First parameter present |
| prm1 | input | 8 | Second parameter byte |
| prm1_vld | input | 1 | Second parameter present |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 9 | Word assembled by the last read |
| lcd_cs_n | output | 1 | Serial select, active low |
| lcd_sck | output | 1 | Serial clock |
| lcd_sdo | output | 1 | Serial data out |
| lcd_sdi | input | 1 | Serial data in |

## Verification
Every result is due a fixed number of cycles after an earlier event. Select falls SETUP_HALVES×HALF_DIV cycles after `busy` rises. Each window and each clock phase has the length given in R2. `busy` falls, together with the `done` pulse, GAP_HALVES×HALF_DIV cycles after the last select rise. `rdata` is read at that point.

A line monitor samples on the falling clock edge and counts cycles between these events. It compares each distance with the exact value and assembles the words from the data-out value seen at each rising serial clock. A modelled device drives data-in just after each rising serial clock, so the value is steady well before the block samples it.

// File: rtl/lcd3w_pkg.sv
package lcd3w_pkg;
    localparam int WORD_W = 9;
    localparam int BIT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LO,
        ST_HI,
        ST_TAIL
    } lcd3w_st_e;
endpackage

// File: rtl/lcd3w_tick.sv
module lcd3w_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_DIV > 1) begin : g_spaced
            // R2: half-bit ticks are at least two cycles apart
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/lcd3w_wordsel.sv
module lcd3w_wordsel
    import lcd3w_pkg::*;
(
    input  logic [1:0]        idx,
    input  logic              rd,
    input  logic [7:0]        cmd,
    input  logic [7:0]        p0,
    input  logic              p0v,
    input  logic [7:0]        p1,
    input  logic              p1v,
    output logic [WORD_W-1:0] word,
    output logic              last,
    output logic              rd_word
);
    always_comb begin
        word    = {1'b0, cmd};
        last    = 1'b1;
        rd_word = 1'b0;
        unique case (idx)
            2'd0: begin
                word = {1'b0, cmd};
                last = rd ? 1'b0 : !p0v;
            end
            2'd1: begin
                if (rd) begin
                    word    = '1;
                    rd_word = 1'b1;
                    last    = 1'b1;
                end else begin
                    word = {1'b1, p0};
                    last = !p1v;
                end
            end
            default: begin
                word = {1'b1, p1};
                last = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lcd3w_writer.sv
module lcd3w_writer
    import lcd3w_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int SETUP_HALVES = 30,
    parameter int GAP_HALVES   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_en,
    input  logic [7:0]        cmd,
    input  logic [7:0]        prm0,
    input  logic              prm0_vld,
    input  logic [7:0]        prm1,
    input  logic              prm1_vld,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              lcd_cs_n,
    output logic              lcd_sck,
    output logic              lcd_sdo,
    input  logic              lcd_sdi
);
    localparam int GMAX = (SETUP_HALVES > GAP_HALVES) ? SETUP_HALVES : GAP_HALVES;
    localparam int GW   = $clog2(GMAX + 1);
    localparam logic [GW-1:0] SETUP_LD = GW'(SETUP_HALVES);
    localparam logic [GW-1:0] GAP_LD   = GW'(GAP_HALVES);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        lcd3w_st_e         st;
        logic [GW-1:0]     gap;
        logic [BIT_W-1:0]  bitn;
        logic [1:0]        idx;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx;
        logic              samp;
        logic              cs;
        logic              sck;
        logic              sdo;
        logic              done;
        logic              rd;
        logic [7:0]        cmd;
        logic [7:0]        p0;
        logic              p0v;
        logic [7:0]        p1;
        logic              p1v;
    } lcd3w_regs_t;

    lcd3w_regs_t d, q;
    logic tick;
    logic [WORD_W-1:0] cur_word;
    logic cur_last, cur_rd;

    lcd3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != ST_IDLE),
        .tick (tick)
    );

    lcd3w_wordsel u_sel (
        .idx    (q.idx),
        .rd     (q.rd),
        .cmd    (q.cmd),
        .p0     (q.p0),
        .p0v    (q.p0v),
        .p1     (q.p1),
        .p1v    (q.p1v),
        .word   (cur_word),
        .last   (cur_last),
        .rd_word(cur_rd)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.samp) begin
            d.rx   = {q.rx[WORD_W-2:0], lcd_sdi};
            d.samp = 1'b0;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_GAP;
                    d.gap  = SETUP_LD;
                    d.idx  = 2'd0;
                    d.cs   = 1'b1;
                    d.sck  = 1'b0;
                    d.sdo  = 1'b1;
                    d.rd   = rd_en;
                    d.cmd  = cmd;
                    d.p0   = prm0;
                    d.p0v  = prm0_vld;
                    d.p1   = prm1;
                    d.p1v  = prm1_vld;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap == GW'(1)) begin
                        d.st   = ST_LO;
                        d.cs   = 1'b0;
                        d.sh   = cur_word;
                        d.bitn = '0;
                        d.sdo  = cur_rd ? 1'b1 : cur_word[WORD_W-1];
                    end else begin
                        d.gap = q.gap - 1'b1;
                    end
                end
            end
            ST_LO: begin
                if (tick) begin
                    d.st  = ST_HI;
                    d.sck = 1'b1;
                end
            end
            ST_HI: begin
                if (tick) begin
                    d.sck = 1'b0;
                    if (cur_rd) d.samp = 1'b1;
                    if (q.bitn == LAST_BIT) begin
                        d.cs  = 1'b1;
                        d.gap = GAP_LD;
                        if (cur_last) begin
                            d.st  = ST_TAIL;
                            d.sdo = 1'b0;
                        end else begin
                            d.st  = ST_GAP;
                            d.idx = q.idx + 1'b1;
                            d.sdo = 1'b1;
                        end
                    end else begin
                        d.st   = ST_LO;
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                        d.sdo  = cur_rd ? 1'b1 : q.sh[WORD_W-2];
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (q.gap == GW'(1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.gap = q.gap - 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cs  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign rdata    = q.rx;
    assign lcd_cs_n = q.cs;
    assign lcd_sck  = q.sck;
    assign lcd_sdo  = q.sdo;

    // R2: clock pulses only inside a select window
    a_r2_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sck |-> !lcd_cs_n);
    // R2: the serial clock moves only on a half-bit tick
    a_r2_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lcd_sck));
    // R3: data-out is frozen while the clock stays high
    a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_sck |=> (!lcd_sck || $stable(lcd_sdo)));
    // R7: done lasts a single cycle and only once busy is low
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: select is released when the clock is low
    a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> !lcd_sck);
    // R8: a start during a transaction leaves the latched command alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.cmd));
endmodule

// File: tb/tb_lcd3w_writer.sv
module tb_lcd3w_writer;
    localparam int H = 4;
    localparam int S = 30;
    localparam int G = 10;

    typedef struct packed {
        logic       rd;
        logic [7:0] cmd;
        logic [7:0] p0;
        logic       p0v;
        logic [7:0] p1;
        logic       p1v;
        logic [8:0] rpat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 9'h000},
        '{1'b0, 8'h36, 8'h00, 1'b1, 8'h00, 1'b0, 9'h000},
        '{1'b0, 8'hB9, 8'h01, 1'b1, 8'hFF, 1'b1, 9'h000},
        '{1'b0, 8'h3A, 8'h70, 1'b0, 8'h55, 1'b1, 9'h000},
        '{1'b0, 8'hFF, 8'h80, 1'b1, 8'h01, 1'b0, 9'h000},
        '{1'b1, 8'h0A, 8'h00, 1'b0, 8'h00, 1'b0, 9'h1A5},
        '{1'b1, 8'hDB, 8'h33, 1'b1, 8'h44, 1'b1, 9'h05A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd_en = 1'b0, prm0_vld = 1'b0, prm1_vld = 1'b0;
    logic [7:0] cmd = '0, prm0 = '0, prm1 = '0;
    logic busy, done, lcd_cs_n, lcd_sck, lcd_sdo;
    logic [8:0] rdata;
    logic sdi = 1'b0;

    always #10 clk = ~clk;

    lcd3w_writer #(.HALF_DIV(H), .SETUP_HALVES(S), .GAP_HALVES(G)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .cmd(cmd),
        .prm0(prm0), .prm0_vld(prm0_vld), .prm1(prm1), .prm1_vld(prm1_vld),
        .busy(busy), .done(done), .rdata(rdata), .lcd_cs_n(lcd_cs_n),
        .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo), .lcd_sdi(sdi)
    );

    int checks = 0;
    int fails = 0;

    // line monitor state, written only by the monitor
    logic mon_clr = 1'b0;
    logic rd_mode = 1'b0;
    logic [8:0] rpat = '0;
    int nwords, wbits, t_ev, t_sck, tbad, sdo_bad, done_cnt, done_bad, tail_len;
    logic [8:0] cur;
    logic [8:0] wbuf [4];
    int wb [4];
    int low_len [4];
    int gap_len [4];
    logic gap_sdo [4];
    logic [2:0] end_state;
    logic cs_p = 1'b1, sck_p = 1'b0, sdo_p = 1'b0, busy_p = 1'b0;

    always @(negedge clk) begin
        int tn, ts;
        if (mon_clr) begin
            nwords = 0; wbits = 0; t_ev = 0; t_sck = 0; tbad = 0; sdo_bad = 0;
            done_cnt = 0; done_bad = 0; tail_len = -1; cur = '0; sdi = 1'b0;
            end_state = 3'b000;
            for (int i = 0; i < 4; i++) begin
                wbuf[i] = '0; wb[i] = 0; low_len[i] = 0; gap_len[i] = 0; gap_sdo[i] = 1'b0;
            end
        end else begin
            tn = t_ev + 1;
            ts = t_sck + 1;
            t_ev = tn;
            t_sck = ts;
            if (busy && !busy_p) t_ev = 0;
            if (!lcd_cs_n && cs_p) begin
                if (nwords < 4) begin
                    gap_len[nwords] = tn;
                    gap_sdo[nwords] = sdo_p;
                end
                t_ev = 0; t_sck = 0; cur = '0; wbits = 0;
            end
            if (lcd_cs_n && !cs_p) begin
                if (nwords < 4) begin
                    low_len[nwords] = tn;
                    wbuf[nwords] = cur;
                    wb[nwords] = wbits;
                end
                nwords++;
                t_ev = 0;
            end
            if (lcd_sck && !sck_p) begin
                if (ts != H) tbad++;
                if (lcd_cs_n) tbad++;
                t_sck = 0;
                if (rd_mode && nwords == 1 && wbits < 9) sdi = rpat[8 - wbits];
                cur = {cur[7:0], lcd_sdo};
                wbits++;
            end
            if (!lcd_sck && sck_p) begin
                if (ts != H) tbad++;
                t_sck = 0;
            end
            if (lcd_sck && sck_p && (lcd_sdo != sdo_p)) sdo_bad++;
            if (!busy && busy_p) begin
                tail_len = tn;
                end_state = {lcd_cs_n, lcd_sck, lcd_sdo};
            end
            if (done) begin
                done_cnt++;
                if (busy) done_bad++;
            end
        end
        cs_p = lcd_cs_n; sck_p = lcd_sck; sdo_p = lcd_sdo; busy_p = busy;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic launch(input vec_t v);
        rd_mode = v.rd; rpat = v.rpat;
        clear_mon();
        rd_en = v.rd; cmd = v.cmd; prm0 = v.p0; prm0_vld = v.p0v;
        prm1 = v.p1; prm1_vld = v.p1v; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_txn(input vec_t v, input string tag);
        logic [8:0] exp [3];
        int n;
        exp[0] = {1'b0, v.cmd};
        if (v.rd) begin
            n = 2; exp[1] = 9'h1FF; exp[2] = '0;
        end else begin
            n = 1 + int'(v.p0v) + int'(v.p0v & v.p1v);
            exp[1] = {1'b1, v.p0}; exp[2] = {1'b1, v.p1};
        end
        chk(nwords == n, {"R5 word count ", tag}, nwords, n);
        for (int i = 0; i < n && i < 3; i++) begin
            chk(wbuf[i] == exp[i], (v.rd && i == 1) ? {"R6 read window sdo ", tag} : {"R1 word value ", tag}, wbuf[i], exp[i]);
            chk(wb[i] == 9, {"R2 pulses per window ", tag}, wb[i], 9);
            chk(low_len[i] == 18 * H, {"R2 window length ", tag}, low_len[i], 18 * H);
            chk(gap_len[i] == ((i == 0) ? S * H : G * H), {"R4 gap length ", tag}, gap_len[i], (i == 0) ? S * H : G * H);
            chk(gap_sdo[i] == 1'b1, {"R4 sdo high in gap ", tag}, gap_sdo[i], 1);
        end
        chk(tbad == 0, {"R2 phase timing ", tag}, tbad, 0);
        chk(sdo_bad == 0, {"R3 sdo stable in high phase ", tag}, sdo_bad, 0);
        chk(tail_len == G * H, {"R7 closing gap ", tag}, tail_len, G * H);
        chk(end_state == 3'b100, {"R7 end line state ", tag}, end_state, 3'b100);
        chk(done_cnt == 1 && done_bad == 0, {"R7 done pulse ", tag}, done_cnt, 1);
        if (v.rd) chk(rdata == v.rpat, {"R6 read data ", tag}, rdata, v.rpat);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({lcd_cs_n, lcd_sck, lcd_sdo} == 3'b100, "R9 line state in reset", {lcd_cs_n, lcd_sck, lcd_sdo}, 3'b100);
        chk({busy, done} == 2'b00, "R9 status in reset", {busy, done}, 0);
        chk(rdata == '0, "R9 rdata in reset", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({lcd_cs_n, lcd_sck, lcd_sdo, busy} == 4'b1000, "R9 idle after reset", {lcd_cs_n, lcd_sck, lcd_sdo, busy}, 4'b1000);

        for (int k = 0; k < NV; k++) begin
            launch(VECS[k]);
            wait_end();
            check_txn(VECS[k], $sformatf("vec%0d", k));
        end

        // R8: start pulses during a transaction are ignored
        launch(VECS[2]);
        repeat (50) @(negedge clk);
        cmd = 8'h11; prm0_vld = 1'b0; rd_en = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_end();
        repeat (S * H) @(negedge clk);
        chk(!busy, "R8 no second transaction", busy, 0);
        check_txn(VECS[2], "R8 busy start");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule